// File: doc/BRIEF.md
# Floppy Logical-to-Physical Sector Mapper

This block translates between the two orderings used for blocks on a single-sided floppy. One is a flat sequence of logical block numbers. The other is a physical address made of a track and a sector. The physical layout combines three rules:

- Consecutive blocks inside a track sit on every other sector.
- Each track's starting sector is shifted by two sectors more than the track before it.
- Logical tracks are rotated by one, so the final logical track lives on physical track 0.

A direction input picks the conversion for each request. It is either logical-to-physical or physical-to-logical.

Requests enter through a valid/ready handshake, and one request can be accepted on every clock. Each result is registered and appears one clock after its request is taken. The result carries a range-error flag for a block number past the end of the disk, or for a track or sector outside the geometry. The default geometry is 80 tracks of 10 sectors, which gives 800 blocks. Sectors are numbered from 1.

Top module: `flp_sector_map`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Forward (in_dir = 0) physical track: out_track = (in_lbn / 10 + 1) mod 80.
- R3: Forward physical sector: let t = in_lbn / 10 and i = in_lbn mod 10. The slot is 2i when i < 5, and 2(i-5)+1 otherwise. Then out_sector = ((slot + 2t) mod 10) + 1, a value from 1 to 10.
- R4: Inverse (in_dir = 1) converts in_track and in_sector back to the block number that the forward rule maps to that address. Running the inverse on the forward result gives back the original block for all 800 blocks.
- R5: In forward mode, in_track and in_sector are ignored and out_lbn is 0. In inverse mode, in_lbn is ignored and out_track and out_sector are 0.
- R6: A forward request with in_lbn >= 800 returns out_err = 1, with out_lbn, out_track and out_sector all 0.
- R7: An inverse request with in_sector = 0, in_sector > 10 or in_track >= 80 returns out_err = 1, with all address outputs 0.
- R8: A request is accepted on a clock edge where in_valid and in_ready are both 1. Its result is presented with out_valid = 1 from the next edge. in_ready = !out_valid || out_ready, so one request per cycle streams through when out_ready stays 1.
- R9: While out_valid = 1 and out_ready = 0, the outputs hold their values and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_dir | input | 1 | 0: block to track/sector, 1: track/sector to block |
| in_lbn | input | 10 | Logical block number (forward) |
| in_track | input | 7 | Physical track (inverse) |
| in_sector | input | 4 | Physical sector, 1-based (inverse) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Request was out of range |
| out_lbn | output | 10 | Logical block (inverse result) |
| out_track | output | 7 | Physical track (forward result) |
| out_sector | output | 4 | Physical sector (forward result) |

## Verification
Two events can fall on the same edge: a waiting result is taken by the consumer, and a new request is accepted into the single output register. The bench provokes this in two ways. It streams requests back to back with out_ready held high. It also stalls one result with out_ready low while a second request waits, then releases both on one edge. Each result is judged against an address computed independently in the bench. The check confirms that the stalled result held steady and that the waiting request appeared exactly one clock after it was taken, with none lost or repeated.

// File: rtl/flp_map_pkg.sv
package flp_map_pkg;

    localparam int TRACKS  = 80;
    localparam int SECTORS = 10;
    localparam int SKEW    = 2;
    localparam int BLOCKS  = TRACKS * SECTORS;
    localparam int HALF    = SECTORS / 2;
    localparam int LBN_W   = $clog2(BLOCKS);
    localparam int TRK_W   = $clog2(TRACKS);
    localparam int SEC_W   = $clog2(SECTORS + 1);

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } flp_dir_e;

    typedef struct packed {
        logic             err;
        logic [LBN_W-1:0] lbn;
        logic [TRK_W-1:0] trk;
        logic [SEC_W-1:0] sec;
    } flp_res_t;

    // block number -> physical track and sector
    function automatic flp_res_t flp_fwd(input logic [LBN_W-1:0] lbn);
        flp_res_t r;
        int t;
        int i;
        int slot;
        r = '0;
        if (int'(lbn) >= BLOCKS) begin
            r.err = 1'b1;
        end else begin
            t    = int'(lbn) / SECTORS;
            i    = int'(lbn) % SECTORS;
            slot = (i < HALF) ? 2 * i : 2 * (i - HALF) + 1;
            r.trk = TRK_W'((t + 1) % TRACKS);
            r.sec = SEC_W'(((slot + SKEW * t) % SECTORS) + 1);
        end
        return r;
    endfunction

    // physical track and sector -> block number
    function automatic flp_res_t flp_inv(input logic [TRK_W-1:0] trk,
                                         input logic [SEC_W-1:0] sec);
        flp_res_t r;
        int t;
        int slot;
        int i;
        r = '0;
        if (sec == '0 || int'(sec) > SECTORS || int'(trk) >= TRACKS) begin
            r.err = 1'b1;
        end else begin
            t    = (int'(trk) + TRACKS - 1) % TRACKS;
            slot = (int'(sec) - 1 - ((SKEW * t) % SECTORS) + SECTORS) % SECTORS;
            i    = ((slot % 2) == 0) ? slot / 2 : slot / 2 + HALF;
            r.lbn = LBN_W'(t * SECTORS + i);
        end
        return r;
    endfunction

endpackage

// File: rtl/flp_xlate.sv
module flp_xlate
    import flp_map_pkg::*;
(
    input  flp_dir_e         dir,
    input  logic [LBN_W-1:0] lbn,
    input  logic [TRK_W-1:0] trk,
    input  logic [SEC_W-1:0] sec,
    output flp_res_t         res
);
    flp_res_t fwd_res;
    flp_res_t inv_res;

    always_comb begin
        fwd_res = flp_fwd(lbn);
        inv_res = flp_inv(trk, sec);
        res     = (dir == DIR_INV) ? inv_res : fwd_res;
    end
endmodule

// File: rtl/flp_stage.sv
module flp_stage
    import flp_map_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  flp_res_t nxt,
    output logic     out_valid,
    input  logic     out_ready,
    output flp_res_t q
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) q <= nxt;
        end
    end

    // R8: an accepted request is presented on the next edge
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R8: nothing accepted and nothing held leaves the output empty
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid && in_ready |=> !out_valid);

    // R9: a stalled result stays put
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(q));

    // R6 / R7: an error result carries no address
    p_err_clean_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && q.err |-> q.lbn == '0 && q.trk == '0 && q.sec == '0);

    // R3: a forward sector is within 1..SECTORS and the track in range
    p_sector_range_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && !q.err && q.sec != '0 |->
            int'(q.sec) <= SECTORS && int'(q.trk) < TRACKS);
endmodule

// File: rtl/flp_sector_map.sv
module flp_sector_map
    import flp_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dir,
    input  logic [LBN_W-1:0] in_lbn,
    input  logic [TRK_W-1:0] in_track,
    input  logic [SEC_W-1:0] in_sector,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic [LBN_W-1:0] out_lbn,
    output logic [TRK_W-1:0] out_track,
    output logic [SEC_W-1:0] out_sector
);
    flp_res_t xl_res;
    flp_res_t st_q;
    flp_dir_e dir_e;

    assign dir_e = flp_dir_e'(in_dir);

    flp_xlate u_xlate (
        .dir (dir_e),
        .lbn (in_lbn),
        .trk (in_track),
        .sec (in_sector),
        .res (xl_res)
    );

    flp_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .nxt       (xl_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (st_q)
    );

    assign out_err    = st_q.err;
    assign out_lbn    = st_q.lbn;
    assign out_track  = st_q.trk;
    assign out_sector = st_q.sec;
endmodule

// File: tb/sim_flp_sector_map.sv
module sim_flp_sector_map;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic       in_dir;
    logic [9:0] in_lbn;
    logic [6:0] in_track;
    logic [3:0] in_sector;
    logic       out_valid;
    logic       out_ready;
    logic       out_err;
    logic [9:0] out_lbn;
    logic [6:0] out_track;
    logic [3:0] out_sector;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flp_sector_map u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_dir(in_dir), .in_lbn(in_lbn), .in_track(in_track),
        .in_sector(in_sector), .out_valid(out_valid), .out_ready(out_ready),
        .out_err(out_err), .out_lbn(out_lbn), .out_track(out_track),
        .out_sector(out_sector)
    );

    function automatic int m_trk(int lbn);
        return (lbn / 10 + 1) % 80;
    endfunction

    function automatic int m_sec(int lbn);
        int t = lbn / 10;
        int i = lbn % 10;
        int slot = (i < 5) ? 2 * i : 2 * i - 9;
        return ((slot + 2 * t) % 10) + 1;
    endfunction

    // search-based inverse, -1 when out of range
    function automatic int m_inv(int trk, int sec);
        int found = -1;
        if (sec < 1 || sec > 10 || trk >= 80) return -1;
        for (int b = 0; b < 800; b++)
            if (m_trk(b) == trk && m_sec(b) == sec) found = b;
        return found;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one request, sampled one clock after acceptance
    task automatic req1(input logic dir, input int lbn, input int trk, input int sec);
        @(negedge clk);
        in_valid  = 1'b1;
        in_dir    = dir;
        in_lbn    = 10'(lbn);
        in_track  = 7'(trk);
        in_sector = 4'(sec);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_dir = 1'b0; in_lbn = '0; in_track = '0; in_sector = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_fwd_fixed;
        int lb[6] = '{0, 1, 5, 9, 10, 799};
        int et[6] = '{1, 1, 1, 1, 2, 0};
        int es[6] = '{1, 3, 2, 10, 3, 8};
        for (int k = 0; k < 6; k++) begin
            req1(1'b0, lb[k], 33, 7);   // track/sector inputs must be ignored
            chk("R8 valid", int'(out_valid), 1);
            chk("R2 track", int'(out_track), et[k]);
            chk("R3 sector", int'(out_sector), es[k]);
            chk("R5 fwd lbn zero", int'(out_lbn), 0);
            chk("R6 no err", int'(out_err), 0);
        end
    endtask

    task automatic t_inv_fixed;
        req1(1'b1, 555, 0, 8);
        chk("R4 inv 0/8", int'(out_lbn), 799);
        chk("R5 inv trk zero", int'(out_track), 0);
        chk("R5 inv sec zero", int'(out_sector), 0);
        req1(1'b1, 3, 1, 1);
        chk("R4 inv 1/1", int'(out_lbn), 0);
        req1(1'b1, 0, 2, 3);
        chk("R4 inv 2/3", int'(out_lbn), 10);
    endtask

    task automatic t_roundtrip;
        int pt;
        int ps;
        for (int b = 0; b < 800; b++) begin
            req1(1'b0, b, 0, 0);
            pt = int'(out_track);
            ps = int'(out_sector);
            chk("R2 sweep", pt, m_trk(b));
            chk("R3 sweep", ps, m_sec(b));
            req1(1'b1, 0, pt, ps);
            chk("R4 round trip", int'(out_lbn), b);
            chk("R4 no err", int'(out_err), 0);
        end
        for (int s = 1; s <= 10; s++) begin
            req1(1'b1, 0, 45, s);
            chk("R4 model", int'(out_lbn), m_inv(45, s));
        end
    endtask

    task automatic t_range;
        int bad_l[3] = '{800, 801, 1023};
        int bad_t[4] = '{3, 3, 3, 80};
        int bad_s[4] = '{0, 11, 15, 5};
        for (int k = 0; k < 3; k++) begin
            req1(1'b0, bad_l[k], 0, 0);
            chk("R6 err", int'(out_err), 1);
            chk("R6 trk zero", int'(out_track), 0);
            chk("R6 sec zero", int'(out_sector), 0);
        end
        for (int k = 0; k < 4; k++) begin
            req1(1'b1, 0, bad_t[k], bad_s[k]);
            chk("R7 err", int'(out_err), 1);
            chk("R7 lbn zero", int'(out_lbn), 0);
        end
    endtask

    task automatic t_stream;
        for (int k = 0; k <= 10; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk("R8 stream valid", int'(out_valid), 1);
                chk("R8 stream sector", int'(out_sector), m_sec(100 + k - 1));
                chk("R8 stream track", int'(out_track), m_trk(100 + k - 1));
            end
            in_valid = (k < 10);
            in_dir   = 1'b0;
            in_lbn   = 10'(100 + k);
        end
        @(negedge clk);
        chk("R8 drained", int'(out_valid), 0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_dir = 1'b0; in_lbn = 10'd357;
        @(negedge clk);
        in_lbn = 10'd358;
        chk("R9 ready low", int'(in_ready), 0);
        @(negedge clk);
        chk("R9 held valid", int'(out_valid), 1);
        chk("R9 held sector", int'(out_sector), m_sec(357));
        chk("R9 held track", int'(out_track), m_trk(357));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 after release", int'(out_sector), m_sec(358));
        @(negedge clk);
        chk("R8 empty", int'(out_valid), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fwd_fixed();
                t_inv_fixed();
                t_range();
                t_stream();
                t_stall();
                t_roundtrip();
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule